// File: doc/BRIEF.md
# Viterbi Compare-Select-Store Unit

This block performs one add-compare-select step of a Viterbi butterfly per clock. A 40-bit accumulator value arrives holding two 16-bit path metrics, one in its high word (bits 31 to 16) and one in its low word (bits 15 to 0), above eight guard bits (39 to 32). A split ALU treats the two words as independent 16-bit lanes. Each lane adds or subtracts its own branch metric. No carry or borrow passes between the lanes, and the guard bits pass through untouched.

The compare-select-store stage then compares the two new words as signed numbers. It records the decision in a test flag and shifts the same decision into a 16-bit transition-history register, which keeps the last sixteen decisions for a later traceback. It also presents the larger word, with a valid strobe, for a write to data memory. A synchronous clear empties the history and the flag.

A small controller sequences the strobe. It has two states. S_IDLE means no store word is pending. S_EMIT means the store word from the previous cycle's step is valid. The controller has two transitions:
- GO_EMIT is taken from either state when start is high and clear is low.
- GO_IDLE is taken from either state otherwise.

Top module: `viterbi_acs_unit`

## Requirements
- R1: After reset, acs_acc, acs_tc, acs_hist, store_data and store_valid are all zero.
- R2: On a step (start high, clr low), acs_acc[31:16] becomes acc_in[31:16] plus bm_hi when sub_hi is 0, or minus bm_hi when sub_hi is 1, modulo 2^16. acs_acc[15:0] follows the same rule with bm_lo and sub_lo. The result appears on the clock edge that ends the step cycle.
- R3: Neither lane's carry or borrow reaches the other lane. A low-lane sum that wraps past 0xFFFF, or a difference that wraps below zero, leaves the high-lane result exactly as R2 gives it.
- R4: On a step, acs_acc[39:32] becomes a copy of acc_in[39:32].
- R5: On a step, acs_tc becomes 1 when the new high word, read as signed 16-bit, is strictly greater than the new low word, and 0 otherwise (equal words give 0).
- R6: On a step, acs_hist shifts left by one place, its bit 15 is dropped, and the new acs_tc value enters bit 0.
- R7: On a step, store_data becomes the new high word when it wins the R5 comparison, and the new low word otherwise. store_valid is 1 in exactly the cycle after each step and 0 after every other cycle.
- R8: In a cycle with start low and clr low, acs_acc, acs_tc, acs_hist and store_data keep their values.
- R9: In a cycle with clr high, acs_hist and acs_tc become zero at the next edge. A start in the same cycle is ignored: acs_acc and store_data keep their values, and store_valid is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of history and flag; takes priority over start |
| start | input | 1 | Perform one ACS step this cycle |
| sub_hi | input | 1 | High lane operation: 0 add, 1 subtract |
| sub_lo | input | 1 | Low lane operation: 0 add, 1 subtract |
| acc_in | input | 40 | Accumulator: guard 39:32, high metric 31:16, low metric 15:0 |
| bm_hi | input | 16 | Branch metric for the high lane |
| bm_lo | input | 16 | Branch metric for the low lane |
| acs_acc | output | 40 | Registered accumulator result of the last step |
| acs_tc | output | 1 | Decision of the last step (1: high word won) |
| acs_hist | output | 16 | Transition history, newest decision in bit 0 |
| store_data | output | 16 | Larger metric of the last step |
| store_valid | output | 1 | store_data is fresh this cycle |

## Verification
Every result of a step is due at the single rising edge that ends the cycle in which start was sampled. This covers the accumulator, flag, history, store word and strobe, and a clear lands at that same edge. The bench drives inputs on the falling edge and samples all outputs on the next falling edge, half a cycle after the edge that updates them. It then compares them with a model advanced once per cycle. Idle and clear cycles are checked in the same slot, so a stray update or a late strobe shows up one cycle later as a mismatch.

// File: rtl/acs_pkg.sv
package acs_pkg;
    localparam int LANE_W  = 16;
    localparam int GUARD_W = 8;
    localparam int HIST_W  = 16;
    localparam int ACC_W   = GUARD_W + 2 * LANE_W;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } acs_state_e;
endpackage

// File: rtl/dual_lane_alu.sv
module dual_lane_alu #(
    parameter int LANE_W  = 16,
    parameter int GUARD_W = 8,
    localparam int ACC_W  = GUARD_W + 2 * LANE_W
) (
    input  logic [ACC_W-1:0]    acc_in,
    input  logic [2*LANE_W-1:0] bm_pair,   // {hi, lo}
    input  logic [1:0]          sub_pair,  // {hi, lo}
    output logic [ACC_W-1:0]    acc_res
);
    // Each lane is computed in isolation; no carry path between them.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [LANE_W-1:0] opa;
        logic [LANE_W-1:0] opb;
        assign opa = acc_in[g*LANE_W +: LANE_W];
        assign opb = bm_pair[g*LANE_W +: LANE_W];
        assign acc_res[g*LANE_W +: LANE_W] = sub_pair[g] ? (opa - opb) : (opa + opb);
    end

    assign acc_res[ACC_W-1 -: GUARD_W] = acc_in[ACC_W-1 -: GUARD_W];
endmodule

// File: rtl/cssu_compare.sv
module cssu_compare #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] word_hi,
    input  logic [LANE_W-1:0] word_lo,
    output logic              hi_wins,
    output logic [LANE_W-1:0] max_word
);
    always_comb begin
        hi_wins  = ($signed(word_hi) > $signed(word_lo));
        max_word = hi_wins ? word_hi : word_lo;
    end
endmodule

// File: rtl/trn_history.sv
module trn_history #(
    parameter int HIST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], bit_in};
        end
    end

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr) |=> (hist_q == {$past(hist_q[HIST_W-2:0]), $past(bit_in)}));

    // R9
    hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (hist_q == '0));

    // R8
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clr) |=> $stable(hist_q));
endmodule

// File: rtl/viterbi_acs_unit.sv
module viterbi_acs_unit
    import acs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               start,
    input  logic               sub_hi,
    input  logic               sub_lo,
    input  logic [ACC_W-1:0]   acc_in,
    input  logic [LANE_W-1:0]  bm_hi,
    input  logic [LANE_W-1:0]  bm_lo,
    output logic [ACC_W-1:0]   acs_acc,
    output logic               acs_tc,
    output logic [HIST_W-1:0]  acs_hist,
    output logic [LANE_W-1:0]  store_data,
    output logic               store_valid
);
    acs_state_e        state_q;
    acs_state_e        state_d;
    logic              step;
    logic [ACC_W-1:0]  alu_res;
    logic              cmp_hi_wins;
    logic [LANE_W-1:0] cmp_max;
    logic [ACC_W-1:0]  acc_q;
    logic              tc_q;
    logic [LANE_W-1:0] st_q;

    assign step = start && !clr;

    dual_lane_alu #(.LANE_W(LANE_W), .GUARD_W(GUARD_W)) u_alu (
        .acc_in   (acc_in),
        .bm_pair  ({bm_hi, bm_lo}),
        .sub_pair ({sub_hi, sub_lo}),
        .acc_res  (alu_res)
    );

    cssu_compare #(.LANE_W(LANE_W)) u_cmp (
        .word_hi  (alu_res[2*LANE_W-1:LANE_W]),
        .word_lo  (alu_res[LANE_W-1:0]),
        .hi_wins  (cmp_hi_wins),
        .max_word (cmp_max)
    );

    trn_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (step),
        .bit_in   (cmp_hi_wins),
        .hist_q   (acs_hist)
    );

    // Next-state logic
    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE: state_d = step ? S_EMIT : S_IDLE;
            S_EMIT: state_d = step ? S_EMIT : S_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            acc_q   <= '0;
            tc_q    <= 1'b0;
            st_q    <= '0;
        end else begin
            state_q <= state_d;
            if (clr) begin
                tc_q <= 1'b0;
            end else if (start) begin
                acc_q <= alu_res;
                tc_q  <= cmp_hi_wins;
                st_q  <= cmp_max;
            end
        end
    end

    // Outputs
    always_comb begin
        acs_acc     = acc_q;
        acs_tc      = tc_q;
        store_data  = st_q;
        store_valid = (state_q == S_EMIT);
    end

    // R7
    valid_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> store_valid);

    // R7
    valid_only_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !store_valid);

    // R7
    store_is_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_valid |-> (store_data == (acs_tc ? acs_acc[2*LANE_W-1:LANE_W] : acs_acc[LANE_W-1:0])));

    // R4
    guard_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (acs_acc[ACC_W-1 -: GUARD_W] == $past(acc_in[ACC_W-1 -: GUARD_W])));

    // R6
    tc_into_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (acs_hist[0] == acs_tc));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !clr) |=> ($stable(acs_acc) && $stable(acs_tc) && $stable(store_data)));

    // R9
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!acs_tc && $stable(acs_acc) && $stable(store_data)));
endmodule

// File: tb/viterbi_acs_unit_tb.sv
module viterbi_acs_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        start = 1'b0;
    logic        sub_hi = 1'b0;
    logic        sub_lo = 1'b0;
    logic [39:0] acc_in = '0;
    logic [15:0] bm_hi = '0;
    logic [15:0] bm_lo = '0;
    logic [39:0] acs_acc;
    logic        acs_tc;
    logic [15:0] acs_hist;
    logic [15:0] store_data;
    logic        store_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    logic [39:0] m_acc = '0;
    logic        m_tc = 1'b0;
    logic [15:0] m_hist = '0;
    logic [15:0] m_st = '0;
    logic        m_val = 1'b0;

    viterbi_acs_unit u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(start),
        .sub_hi(sub_hi), .sub_lo(sub_lo), .acc_in(acc_in),
        .bm_hi(bm_hi), .bm_lo(bm_lo), .acs_acc(acs_acc), .acs_tc(acs_tc),
        .acs_hist(acs_hist), .store_data(store_data), .store_valid(store_valid)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] lane_op(input logic [15:0] a, input logic [15:0] b, input logic s);
        logic [16:0] wide;
        if (s) wide = {1'b0, a} + {1'b0, ~b} + 17'd1;
        else   wide = {1'b0, a} + {1'b0, b};
        return wide[15:0];
    endfunction

    function automatic logic hi_greater(input logic [15:0] h, input logic [15:0] l);
        int ih;
        int il;
        ih = h[15] ? int'(h) - 65536 : int'(h);
        il = l[15] ? int'(l) - 65536 : int'(l);
        return ih > il;
    endfunction

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R2 acc low 32"}, {8'h0, acs_acc[31:0]}, {8'h0, m_acc[31:0]});
        chk({tag, " R4 guard"}, {32'h0, acs_acc[39:32]}, {32'h0, m_acc[39:32]});
        chk({tag, " R5 tc"}, {39'h0, acs_tc}, {39'h0, m_tc});
        chk({tag, " R6 hist"}, {24'h0, acs_hist}, {24'h0, m_hist});
        chk({tag, " R7 store_data"}, {24'h0, store_data}, {24'h0, m_st});
        chk({tag, " R7 store_valid"}, {39'h0, store_valid}, {39'h0, m_val});
    endtask

    task automatic cycle(input string tag, input logic s, input logic c, input logic sh, input logic sl,
                         input logic [39:0] a, input logic [15:0] bh, input logic [15:0] bl);
        logic [15:0] nh;
        logic [15:0] nl;
        logic        d;
        start = s; clr = c; sub_hi = sh; sub_lo = sl; acc_in = a; bm_hi = bh; bm_lo = bl;
        nh = lane_op(a[31:16], bh, sh);
        nl = lane_op(a[15:0], bl, sl);
        d  = hi_greater(nh, nl);
        if (c) begin
            m_tc = 1'b0; m_hist = '0; m_val = 1'b0;
        end else if (s) begin
            m_acc = {a[39:32], nh, nl};
            m_tc = d;
            m_hist = {m_hist[14:0], d};
            m_st = d ? nh : nl;
            m_val = 1'b1;
        end else begin
            m_val = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R1 reset state
        compare_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 after release");

        // R3: low lane wraps upward, high lane must not see carry
        cycle("R3 carry", 1'b1, 1'b0, 1'b0, 1'b0, 40'hA5_1234_FFFF, 16'h0001, 16'h0001);
        // R3: low lane borrow, high lane must not see borrow
        cycle("R3 borrow", 1'b1, 1'b0, 1'b1, 1'b1, 40'h3C_0010_0000, 16'h0000, 16'h0001);
        // R5: equal words give tc 0
        cycle("R5 equal", 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_0100_0100, 16'h0005, 16'h0005);
        // R5: signed compare, 0x8000 is less than 0x7FFF
        cycle("R5 signed", 1'b1, 1'b0, 1'b0, 1'b0, 40'hFF_8000_7FFF, 16'h0000, 16'h0000);
        // R8: idle cycles hold everything
        cycle("R8 idle", 1'b0, 1'b0, 1'b1, 1'b0, 40'h12_3456_789A, 16'h1111, 16'h2222);
        cycle("R8 idle2", 1'b0, 1'b0, 1'b0, 1'b1, 40'h00_0000_0000, 16'hFFFF, 16'hFFFF);
        // R6: 17 winning decisions fill history and drop the oldest
        for (int i = 0; i < 17; i++)
            cycle("R6 fill", 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_0200_0100, 16'h0000, 16'h0000);
        cycle("R6 zero in", 1'b1, 1'b0, 1'b0, 1'b0, 40'h00_0100_0200, 16'h0000, 16'h0000);
        // R9: clear with start in the same cycle
        cycle("R9 clear+start", 1'b1, 1'b1, 1'b0, 1'b0, 40'h77_7FFF_0000, 16'h0000, 16'h0000);
        cycle("R9 clear only", 1'b0, 1'b1, 1'b0, 1'b0, 40'h00_0000_0000, 16'h0000, 16'h0000);

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic s;
            logic c;
            s = ($urandom % 4) != 0;
            c = ($urandom % 16) == 0;
            cycle("R2 random", s, c, 1'($urandom), 1'($urandom),
                  {8'($urandom), 32'($urandom)}, 16'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule